// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Unit

This block executes the second-page (prefixed) instructions of an 8-bit processor core on a single operand byte. A decoder upstream splits the prefixed opcode into a 2-bit class field, a 3-bit selector field and a 3-bit operand-location field. It hands these to the unit with the operand byte and the current flags. The unit returns the result byte and a write-enable that says whether that byte must be stored. It also returns the new flags and the number of machine cycles the instruction occupies, so a sequencer can stall longer when the operand lives in memory.

The operation work is combinational. One output register stage sits between the request side and the response side. Both sides use a valid/ready handshake. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high, and its response appears on the next cycle with `out_valid` high. The response stays put while the consumer holds `out_ready` low. During that stall `in_ready` is low, so no further request is taken, and that back-pressure reaches the producer in the same cycle. When the consumer takes the response on the same edge that a new request arrives, the unit sustains one operation per cycle.

Flags are packed as Z in bit 3, N in bit 2, H in bit 1 and C in bit 0, on both the input and the output.

Top module: `pfx_unit`

## Requirements
- R1: The class field selects the operation: 0 selects the rotate/shift group, 1 selects bit test, 2 selects bit clear and 3 selects bit set.
- R2: In the rotate/shift group, selector values 0 and 1 rotate left and right in a circle. The bit that leaves goes both to C and to the opposite end of the result.
- R3: Selector values 2 and 3 rotate left and right through carry. The incoming C enters the vacated end, and the bit that leaves goes to C.
- R4: Selector 4 is a left shift that brings a zero into bit 0. Selector 5 is a right shift that keeps bit 7 unchanged. Selector 7 is a right shift that clears bit 7. In all three, the bit that leaves goes to C.
- R5: Selector 6 exchanges the high and low nibbles of the operand and clears C.
- R6: Every rotate/shift/swap clears N and H, sets Z exactly when the result is zero, and asserts the write-enable.
- R7: Bit test examines bit y of the operand. It sets Z when that bit is 0, sets H, clears N and keeps C. The write-enable is low and the result equals the operand.
- R8: Bit clear and bit set force bit y of the operand to 0 and 1 respectively. They assert the write-enable and return the flags unchanged.
- R9: The cycle count is 4 when the location field equals 6 (a memory operand) and 2 otherwise, for every class.
- R10: A request accepted at an edge produces `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and every response output holds its value.
- R11: While reset is active, and directly after it, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_x | input | 2 | Class field |
| in_y | input | 3 | Selector / bit index field |
| in_z | input | 3 | Operand location field (6 = memory) |
| in_operand | input | 8 | Operand byte |
| in_flags | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | 8 | Result byte |
| out_wr_en | output | 1 | Result must be written back |
| out_flags | output | 4 | New flags {Z,N,H,C} |
| out_cycles | output | 3 | Machine cycles used (2 or 4) |

## Verification
The bench sweeps every class and selector with both a register location and the memory location. Each combination runs against all 256 operand bytes with the incoming carry both clear and set. The two carry values separate rotate-through-carry from circular rotation, and they show that bit test keeps C while the other groups replace it. Operands whose result is zero (0x00, 0x80, 0x01 and single-bit values) check the Z logic. The untouched Z/N/H input bits vary with the operand, which exposes any flag that bit clear or bit set should pass through unchanged. A separate stall sequence holds `out_ready` low across several cycles, to check that the response holds and that `in_ready` drops.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [1:0] {
    CLS_SHIFT = 2'd0,
    CLS_TEST  = 2'd1,
    CLS_CLEAR = 2'd2,
    CLS_SETB  = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    SH_ROTL   = 3'd0,
    SH_ROTR   = 3'd1,
    SH_ROTLC  = 3'd2,
    SH_ROTRC  = 3'd3,
    SH_SHL    = 3'd4,
    SH_SHRA   = 3'd5,
    SH_NIBX   = 3'd6,
    SH_SHRL   = 3'd7
  } shop_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;
endpackage

// File: rtl/pfx_shifter.sv
module pfx_shifter #(
  parameter int unsigned W = 8
) (
  input  pfx_pkg::shop_e op,
  input  logic [W-1:0]   data,
  input  logic           carry_in,
  output logic [W-1:0]   result,
  output logic           carry_out
);
  import pfx_pkg::*;
  localparam int unsigned HALF = W / 2;

  always_comb begin
    result    = data;
    carry_out = 1'b0;
    unique case (op)
      SH_ROTL:  begin result = {data[W-2:0], data[W-1]}; carry_out = data[W-1]; end
      SH_ROTR:  begin result = {data[0], data[W-1:1]};   carry_out = data[0];   end
      SH_ROTLC: begin result = {data[W-2:0], carry_in};  carry_out = data[W-1]; end
      SH_ROTRC: begin result = {carry_in, data[W-1:1]};  carry_out = data[0];   end
      SH_SHL:   begin result = {data[W-2:0], 1'b0};      carry_out = data[W-1]; end
      SH_SHRA:  begin result = {data[W-1], data[W-1:1]}; carry_out = data[0];   end
      SH_NIBX:  begin result = {data[HALF-1:0], data[W-1:HALF]}; carry_out = 1'b0; end
      SH_SHRL:  begin result = {1'b0, data[W-1:1]};      carry_out = data[0];   end
      default:  begin result = data; carry_out = 1'b0; end
    endcase
  end
endmodule

// File: rtl/pfx_bitops.sv
module pfx_bitops #(
  parameter int unsigned W     = 8,
  parameter int unsigned SEL_W = $clog2(W)
) (
  input  pfx_pkg::cls_e   cls,
  input  logic [SEL_W-1:0] idx,
  input  logic [W-1:0]    data,
  input  pfx_pkg::flags_t flags_in,
  output logic [W-1:0]    result,
  output pfx_pkg::flags_t flags_out,
  output logic            wr_en
);
  import pfx_pkg::*;

  logic [W-1:0] mask;

  generate
    for (genvar g = 0; g < W; g++) begin : g_mask
      assign mask[g] = (idx == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    result    = data;
    flags_out = flags_in;
    wr_en     = 1'b1;
    unique case (cls)
      CLS_TEST: begin
        wr_en       = 1'b0;
        flags_out.z = ~|(data & mask);
        flags_out.n = 1'b0;
        flags_out.h = 1'b1;
      end
      CLS_CLEAR: result = data & ~mask;
      CLS_SETB:  result = data | mask;
      default:   result = data;
    endcase
  end
endmodule

// File: rtl/pfx_cycles.sv
module pfx_cycles #(
  parameter int unsigned CYC_W   = 3,
  parameter int unsigned CYC_REG = 2,
  parameter int unsigned CYC_MEM = 4,
  parameter int unsigned MEM_SEL = 6
) (
  input  logic [2:0]       loc,
  output logic [CYC_W-1:0] cycles
);
  assign cycles = (loc == 3'(MEM_SEL)) ? CYC_W'(CYC_MEM) : CYC_W'(CYC_REG);
endmodule

// File: rtl/pfx_unit.sv
module pfx_unit #(
  parameter int unsigned W       = 8,
  parameter int unsigned CYC_W   = 3,
  parameter int unsigned CYC_REG = 2,
  parameter int unsigned CYC_MEM = 4,
  parameter int unsigned MEM_SEL = 6,
  localparam int unsigned SEL_W  = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_x,
  input  logic [SEL_W-1:0] in_y,
  input  logic [2:0]       in_z,
  input  logic [W-1:0]     in_operand,
  input  logic [3:0]       in_flags,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_result,
  output logic             out_wr_en,
  output logic [3:0]       out_flags,
  output logic [CYC_W-1:0] out_cycles
);
  import pfx_pkg::*;

  cls_e         cls;
  flags_t       fin;
  logic [W-1:0] sh_res;
  logic         sh_c;
  logic [W-1:0] bo_res;
  flags_t       bo_flags;
  logic         bo_we;
  logic [CYC_W-1:0] cyc;
  logic [W-1:0] nx_res;
  flags_t       nx_flags;
  logic         nx_we;
  logic         accept;

  assign cls = cls_e'(in_x);
  assign fin = flags_t'(in_flags);

  pfx_shifter #(.W(W)) u_shift (
    .op(shop_e'(in_y)), .data(in_operand), .carry_in(fin.c),
    .result(sh_res), .carry_out(sh_c)
  );

  pfx_bitops #(.W(W), .SEL_W(SEL_W)) u_bits (
    .cls(cls), .idx(in_y), .data(in_operand), .flags_in(fin),
    .result(bo_res), .flags_out(bo_flags), .wr_en(bo_we)
  );

  pfx_cycles #(.CYC_W(CYC_W), .CYC_REG(CYC_REG), .CYC_MEM(CYC_MEM), .MEM_SEL(MEM_SEL)) u_cyc (
    .loc(in_z), .cycles(cyc)
  );

  always_comb begin
    if (cls == CLS_SHIFT) begin
      nx_res   = sh_res;
      nx_we    = 1'b1;
      nx_flags = '{z: (sh_res == '0), n: 1'b0, h: 1'b0, c: sh_c};
    end else begin
      nx_res   = bo_res;
      nx_we    = bo_we;
      nx_flags = bo_flags;
    end
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      out_flags  <= '0;
      out_cycles <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (accept) begin
        out_result <= nx_res;
        out_wr_en  <= nx_we;
        out_flags  <= nx_flags;
        out_cycles <= cyc;
      end
    end
  end
endmodule

// File: rtl/pfx_unit_chk.sv
module pfx_unit_chk #(
  parameter int unsigned W       = 8,
  parameter int unsigned CYC_W   = 3,
  parameter int unsigned CYC_REG = 2,
  parameter int unsigned CYC_MEM = 4,
  parameter int unsigned MEM_SEL = 6,
  parameter int unsigned SEL_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_x,
  input logic [SEL_W-1:0] in_y,
  input logic [2:0]       in_z,
  input logic [W-1:0]     in_operand,
  input logic [3:0]       in_flags,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_result,
  input logic             out_wr_en,
  input logic [3:0]       out_flags,
  input logic [CYC_W-1:0] out_cycles
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags)
      && $stable(out_cycles) && $stable(out_wr_en));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r10_deliver: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r9_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_cycles == (($past(in_z) == 3'(MEM_SEL)) ? CYC_W'(CYC_MEM) : CYC_W'(CYC_REG)));

  a_r7_test: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_x == 2'd1 |=> !out_wr_en && out_flags[1] && !out_flags[2]
      && out_flags[0] == $past(in_flags[0]) && out_result == $past(in_operand)
      && out_flags[3] == !$past(in_operand[in_y]));

  a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_x[1] |=> out_wr_en && out_flags == $past(in_flags));

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_x == 2'd0 |=> out_wr_en && !out_flags[2] && !out_flags[1]
      && out_flags[3] == (out_result == '0));
endmodule

bind pfx_unit pfx_unit_chk #(
  .W(W), .CYC_W(CYC_W), .CYC_REG(CYC_REG), .CYC_MEM(CYC_MEM), .MEM_SEL(MEM_SEL), .SEL_W(SEL_W)
) u_chk (.*);

// File: tb/pfx_unit_bench.sv
module pfx_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_x = '0;
  logic [2:0] in_y = '0;
  logic [2:0] in_z = '0;
  logic [7:0] in_operand = '0;
  logic [3:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic       out_wr_en;
  logic [3:0] out_flags;
  logic [2:0] out_cycles;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pfx_unit u_pfx_unit (.*);

  // Expected packed as {result[7:0], wr_en, flags[3:0], cycles[2:0]}
  function automatic logic [15:0] model(input logic [1:0] x, input logic [2:0] y,
                                        input logic [2:0] z, input logic [7:0] d,
                                        input logic [3:0] f);
    logic [7:0] r; logic we; logic [3:0] nf; logic c; logic [2:0] cy;
    int u;
    cy = (z == 3'd6) ? 3'd4 : 3'd2;
    r = d; we = 1'b1; nf = f; c = 1'b0;
    u = int'(d);
    case (x)
      2'd0: begin
        case (y)
          3'd0: begin c = d[7]; r = 8'((u * 2) % 256 + u / 128); end
          3'd1: begin c = d[0]; r = 8'(u / 2 + (u % 2) * 128); end
          3'd2: begin c = d[7]; r = 8'((u * 2) % 256 + int'(f[0])); end
          3'd3: begin c = d[0]; r = 8'(u / 2 + int'(f[0]) * 128); end
          3'd4: begin c = d[7]; r = 8'((u * 2) % 256); end
          3'd5: begin c = d[0]; r = 8'(u / 2 + (u / 128) * 128); end
          3'd6: begin c = 1'b0; r = 8'((u % 16) * 16 + u / 16); end
          default: begin c = d[0]; r = 8'(u / 2); end
        endcase
        nf = {(r == 8'd0), 1'b0, 1'b0, c};
      end
      2'd1: begin we = 1'b0; nf = {((u >> y) % 2 == 0), 1'b0, 1'b1, f[0]}; end
      2'd2: r = 8'(u - (((u >> y) % 2) << y));
      default: r = 8'(u + ((1 - (u >> y) % 2) << y));
    endcase
    return {r, we, nf, cy};
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    logic [15:0] act;
    act = {out_result, out_wr_en, out_flags, out_cycles};
    tests++;
    if (!out_valid || act !== exp) begin
      fails++;
      $display("FAIL %s x=%0d y=%0d z=%0d op=%02h f=%h: valid=%b act=%h exp=%h",
               req, in_x, in_y, in_z, in_operand, in_flags, out_valid, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] x, input logic [2:0] y);
    if (x == 2'd1) return "R7";
    if (x != 2'd0) return "R8";
    case (y)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd6: return "R5";
      default: return "R4";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] exp;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    tests++;  // R11 during reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++; $display("FAIL R11 in reset: act=%b%b exp=01", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    tests++;  // R11 after reset
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++; $display("FAIL R11 after reset: act=%b%b exp=01", out_valid, in_ready);
    end

    // R1 R6 R9 sweep: every class and selector, register and memory location
    for (int x = 0; x < 4; x++)
      for (int y = 0; y < 8; y++)
        for (int zs = 0; zs < 2; zs++)
          for (int c = 0; c < 2; c++)
            for (int d = 0; d < 256; d++) begin
              in_x = 2'(x); in_y = 3'(y); in_z = (zs == 1) ? 3'd6 : 3'(d % 6);
              in_operand = 8'(d);
              in_flags = {d[5], d[6], d[7], c[0]};
              in_valid = 1'b1;
              exp = model(in_x, in_y, in_z, in_operand, in_flags);
              @(negedge clk);
              check(req_of(in_x, in_y), exp);
            end

    // R10 back-pressure
    in_x = 2'd0; in_y = 3'd0; in_z = 3'd6; in_operand = 8'h81; in_flags = 4'h0;
    exp = model(in_x, in_y, in_z, in_operand, in_flags);
    @(negedge clk);
    out_ready = 1'b0;
    check("R10", exp);
    held = exp;
    in_x = 2'd3; in_y = 3'd7; in_z = 3'd0; in_operand = 8'h00;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10", held);
      tests++;
      if (in_ready !== 1'b0) begin
        fails++; $display("FAIL R10 in_ready during stall: act=%b exp=0", in_ready);
      end
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R10", model(2'd3, 3'd7, 3'd0, 8'h00, 4'h0));
    in_valid = 1'b0;
    @(negedge clk);
    tests++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R10 drain: act=%b exp=0", out_valid);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule